// File: doc/BRIEF.md
# Linked Page-Table Stream Writer

This block accepts a stream of 32-bit micro-packet words and stores them in host memory, one 4 KiB page at a time. It finds the destination pages itself. Host memory holds a circular chain of descriptor pages. In each descriptor page, the first entries give the frame numbers of buffer pages, and the entry that follows them gives the frame number of the next descriptor page. The final descriptor links back to the first one. A frame number is a byte address shifted right by the page size, so in this design the word address is the frame number followed by the word index inside the page.

Software controls the block through a small write-only register port. Register 5 holds the frame number of the first descriptor. Register 0 takes commands:

- `0x0C000040` starts the walk.
- `0x08080000` stops it.
- `0x00000010` clears the table credit count.
- `0x00000020` adds one credit.

The writer must spend one credit each time it enters a descriptor page. The host adds credits as it hands pages back, and this is the flow control. When no credit is left, the writer stalls and holds its input. The first word written after such a stall carries an overflow marker in bit 24. Words are written in arrival order, so the last word of a page always lands after all the others.

Top module: `dmaw_ring_writer`

## Requirements
- R1: After reset, `mem_req` and `s_ready` are low, and no memory access takes place until a start command is written.
- R2: Writing `0x0C000040` to register 0 starts a walk at the descriptor whose frame number was last written to register 5. The first access is a read of word 0 of that page.
- R3: Buffer frame numbers are read from descriptor entries 0 through BUFS-1 in order. The words of each buffer are written to word indices 0 through 2^PAGE_LG2-1 of that frame, in arrival order, with the last index written last.
- R4: After the last buffer of a descriptor is filled, entry BUFS (the link) is read and the walk continues in the linked descriptor. The chain wraps back to the first descriptor.
- R5: Writing `0x00000010` to register 0 sets the credit count to zero. Writing `0x00000020` adds one credit. Entering a descriptor consumes one credit.
- R6: When a descriptor is entered with zero credits, the block issues no memory request and holds `s_ready` low until a credit arrives.
- R7: The first word written after a zero-credit stall has bit 24 set. Every other word is written unchanged.
- R8: Writing `0x08080000` to register 0 returns the block to idle. After that it issues no further requests and accepts no words.
- R9: A write to register 0 with any other value, or a write to any register other than 0 and 5, has no effect.
- R10: An input word is accepted exactly in a cycle in which it is written, meaning `mem_req`, `mem_we` and `mem_gnt` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Input word valid |
| s_data | input | 32 | Input micro-packet word |
| s_ready | output | 1 | Input word accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | PFN_W+PAGE_LG2 | Word address: frame number followed by word index |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request taken this cycle |
| mem_rvalid | input | 1 | Read data valid (one read outstanding at a time) |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a zero-credit stall that lands exactly on a descriptor boundary, and in particular on the boundary where the chain wraps back to the first descriptor.

The bench builds a three-descriptor chain with small pages and grants the writer exactly as many credits as the descriptors it is allowed to enter. The stream therefore runs dry of credit at the third descriptor and again on the wrap. While the writer is stalled, the bench writes non-matching command values, then releases single credits. A pseudo-random grant pattern on the memory port is applied throughout.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam logic [31:0] CMD_START = 32'h0C00_0040;
  localparam logic [31:0] CMD_STOP  = 32'h0808_0000;
  localparam logic [31:0] CMD_CLEAR = 32'h0000_0010;
  localparam logic [31:0] CMD_GRANT = 32'h0000_0020;
  localparam logic [2:0]  REG_CTRL  = 3'd0;
  localparam logic [2:0]  REG_ROOT  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_RD_BUF, ST_WT_BUF, ST_FILL, ST_RD_LINK, ST_WT_LINK
  } wstate_t;

  function automatic logic [31:0] mark_word(input logic [31:0] d, input logic flag,
                                            input int unsigned pos);
    logic [31:0] m;
    m = 32'(flag) << pos;
    return d | m;
  endfunction
endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs #(
  parameter int PFN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic             start_p,
  output logic             stop_p,
  output logic             clear_p,
  output logic             grant_p,
  output logic [PFN_W-1:0] root_pfn
);
  import dmaw_pkg::*;

  logic ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == REG_CTRL);
  assign start_p = ctrl_wr && (reg_wdata == CMD_START);
  assign stop_p  = ctrl_wr && (reg_wdata == CMD_STOP);
  assign clear_p = ctrl_wr && (reg_wdata == CMD_CLEAR);
  assign grant_p = ctrl_wr && (reg_wdata == CMD_GRANT);

  always_ff @(posedge clk) begin
    if (!rst_n) root_pfn <= '0;
    else if (reg_we && reg_addr == REG_ROOT) root_pfn <= reg_wdata[PFN_W-1:0];
  end
endmodule

// File: rtl/dmaw_credit.sv
module dmaw_credit #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_p,
  input  logic          grant_p,
  input  logic          take_p,
  output logic [CW-1:0] count,
  output logic          has_credit
);
  localparam logic [CW-1:0] CMAX = '1;

  assign has_credit = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_p) count <= '0;
    else begin
      case ({grant_p, take_p})
        2'b10:   if (count != CMAX) count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dmaw_seq.sv
module dmaw_seq #(
  parameter int PFN_W    = 32,
  parameter int PAGE_LG2 = 10,
  parameter int BUFS     = 511,
  parameter int OVF_BIT  = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_p,
  input  logic                      stop_p,
  input  logic [PFN_W-1:0]          root_pfn,
  input  logic                      has_credit,
  output logic                      take_p,
  input  logic                      s_valid,
  input  logic [31:0]               s_data,
  output logic                      s_ready,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [PFN_W+PAGE_LG2-1:0] mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_gnt,
  input  logic                      mem_rvalid,
  input  logic [31:0]               mem_rdata,
  output dmaw_pkg::wstate_t         st_o,
  output logic [PAGE_LG2-1:0]       word_idx_o,
  output logic                      ovf_pend_o,
  output logic                      wr_fire_o,
  output logic                      word_last_o
);
  import dmaw_pkg::*;
  localparam int AW = PFN_W + PAGE_LG2;
  localparam logic [PAGE_LG2-1:0] LINK_IDX = PAGE_LG2'(BUFS);
  localparam logic [PAGE_LG2-1:0] BUF_LAST = PAGE_LG2'(BUFS - 1);

  function automatic logic [AW-1:0] page_addr(input logic [PFN_W-1:0] pfn,
                                              input logic [PAGE_LG2-1:0] idx);
    return {pfn, idx};
  endfunction

  wstate_t             st;
  logic [PFN_W-1:0]    tbl_pfn, buf_pfn;
  logic [PAGE_LG2-1:0] buf_idx, word_idx;
  logic                ovf_pend;
  logic                wr_fire, word_last, buf_last;

  assign word_last = (word_idx == '1);
  assign buf_last  = (buf_idx == BUF_LAST);
  assign s_ready   = (st == ST_FILL) && mem_gnt;
  assign wr_fire   = s_valid && s_ready;
  assign take_p    = (st == ST_ENTER) && has_credit && !start_p && !stop_p;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = page_addr(tbl_pfn, buf_idx);
      end
      ST_RD_LINK: begin
        mem_req  = 1'b1;
        mem_addr = page_addr(tbl_pfn, LINK_IDX);
      end
      ST_FILL: begin
        mem_req   = s_valid;
        mem_we    = 1'b1;
        mem_addr  = page_addr(buf_pfn, word_idx);
        mem_wdata = mark_word(s_data, ovf_pend, OVF_BIT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; tbl_pfn <= '0; buf_pfn <= '0;
      buf_idx <= '0; word_idx <= '0; ovf_pend <= 1'b0;
    end else if (stop_p) begin
      st <= ST_IDLE; ovf_pend <= 1'b0;
    end else if (start_p) begin
      st <= ST_ENTER; tbl_pfn <= root_pfn; buf_idx <= '0;
      word_idx <= '0; ovf_pend <= 1'b0;
    end else begin
      case (st)
        ST_ENTER:
          if (has_credit) st <= ST_RD_BUF;
          else ovf_pend <= 1'b1;
        ST_RD_BUF:
          if (mem_gnt) st <= ST_WT_BUF;
        ST_WT_BUF:
          if (mem_rvalid) begin
            buf_pfn  <= mem_rdata[PFN_W-1:0];
            word_idx <= '0;
            st       <= ST_FILL;
          end
        ST_FILL:
          if (wr_fire) begin
            ovf_pend <= 1'b0;
            word_idx <= word_idx + 1'b1;
            if (word_last) begin
              if (buf_last) st <= ST_RD_LINK;
              else begin
                buf_idx <= buf_idx + 1'b1;
                st      <= ST_RD_BUF;
              end
            end
          end
        ST_RD_LINK:
          if (mem_gnt) st <= ST_WT_LINK;
        ST_WT_LINK:
          if (mem_rvalid) begin
            tbl_pfn <= mem_rdata[PFN_W-1:0];
            buf_idx <= '0;
            st      <= ST_ENTER;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign st_o        = st;
  assign word_idx_o  = word_idx;
  assign ovf_pend_o  = ovf_pend;
  assign wr_fire_o   = wr_fire;
  assign word_last_o = word_last;
endmodule

// File: rtl/dmaw_ring_writer.sv
module dmaw_ring_writer #(
  parameter int PFN_W    = 32,
  parameter int PAGE_LG2 = 10,
  parameter int BUFS     = 511,
  parameter int CW       = 8,
  parameter int OVF_BIT  = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [2:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  input  logic                      s_valid,
  input  logic [31:0]               s_data,
  output logic                      s_ready,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [PFN_W+PAGE_LG2-1:0] mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_gnt,
  input  logic                      mem_rvalid,
  input  logic [31:0]               mem_rdata
);
  logic                start_p, stop_p, clear_p, grant_p, take_p, has_credit;
  logic [PFN_W-1:0]    root_pfn;
  logic [CW-1:0]       credit_cnt;
  dmaw_pkg::wstate_t   seq_st;
  logic [PAGE_LG2-1:0] seq_word_idx;
  logic                seq_ovf_pend, seq_wr_fire, seq_word_last;

  dmaw_regs #(.PFN_W(PFN_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .start_p, .stop_p, .clear_p, .grant_p, .root_pfn
  );

  dmaw_credit #(.CW(CW)) u_credit (
    .clk, .rst_n, .clear_p, .grant_p, .take_p,
    .count(credit_cnt), .has_credit
  );

  dmaw_seq #(.PFN_W(PFN_W), .PAGE_LG2(PAGE_LG2), .BUFS(BUFS), .OVF_BIT(OVF_BIT)) u_seq (
    .clk, .rst_n, .start_p, .stop_p, .root_pfn, .has_credit, .take_p,
    .s_valid, .s_data, .s_ready,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rvalid, .mem_rdata,
    .st_o(seq_st), .word_idx_o(seq_word_idx), .ovf_pend_o(seq_ovf_pend),
    .wr_fire_o(seq_wr_fire), .word_last_o(seq_word_last)
  );
endmodule

// File: rtl/dmaw_chk.sv
module dmaw_chk #(
  parameter int PAGE_LG2 = 10,
  parameter int CW       = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          st,
  input logic                stop_p,
  input logic                take_p,
  input logic [CW-1:0]       credit_cnt,
  input logic                s_valid,
  input logic                s_ready,
  input logic [31:0]         s_data,
  input logic                mem_req,
  input logic                mem_we,
  input logic                mem_gnt,
  input logic [31:0]         mem_wdata,
  input logic                wr_fire,
  input logic                word_last,
  input logic                ovf_pend,
  input logic [PAGE_LG2-1:0] word_idx
);
  import dmaw_pkg::*;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!mem_req && !s_ready));
  // R10
  accept_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (mem_req && mem_we && mem_gnt));
  // R6
  no_credit_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTER) |-> (!mem_req && !s_ready));
  // R5
  credit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_p |-> (credit_cnt != '0));
  // R3
  word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !word_last) |=> (word_idx == PAGE_LG2'($past(word_idx) + 1'b1)));
  // R7
  plain_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !ovf_pend) |-> (mem_wdata == s_data));
  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (st == ST_IDLE));
endmodule

bind dmaw_ring_writer dmaw_chk #(.PAGE_LG2(PAGE_LG2), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(seq_st), .stop_p(stop_p), .take_p(take_p),
  .credit_cnt(credit_cnt), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_wdata(mem_wdata),
  .wr_fire(seq_wr_fire), .word_last(seq_word_last), .ovf_pend(seq_ovf_pend),
  .word_idx(seq_word_idx)
);

// File: tb/sim_dmaw_ring_writer.sv
`timescale 1ns/1ps
module sim_dmaw_ring_writer;
  localparam int PFN_W = 8, PAGE_LG2 = 2, BUFS = 3, WPP = 4, AW = PFN_W + PAGE_LG2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [2:0] reg_addr = '0; logic [31:0] reg_wdata = '0;
  logic s_valid = 1'b0; logic [31:0] s_data = '0; logic s_ready;
  logic mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr; logic [31:0] mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  dmaw_ring_writer #(.PFN_W(PFN_W), .PAGE_LG2(PAGE_LG2), .BUFS(BUFS), .CW(4)) u0 (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .s_valid, .s_data, .s_ready,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_gnt, .mem_rvalid, .mem_rdata);

  logic [31:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] wr_addr_log [0:63]; logic [31:0] wr_data_log [0:63];
  logic [AW-1:0] rd_addr_log [0:63];
  int wr_n = 0, rd_n = 0, req_cnt = 0, cyc = 0;
  int checks = 0, errors = 0;
  logic [7:0] lfsr = 8'h5A;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt <= lfsr[0] | lfsr[2];
    mem_rvalid <= 1'b0;
    if (mem_req) req_cnt <= req_cnt + 1;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (wr_n < 64) begin wr_addr_log[wr_n] <= mem_addr; wr_data_log[wr_n] <= mem_wdata; end
        wr_n <= wr_n + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr];
        if (rd_n < 64) rd_addr_log[rd_n] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  function automatic int tbl_pfn(input int t); return 10 * (t + 1); endfunction
  function automatic int buf_pfn(input int t, input int b); return 100 + t * 8 + b; endfunction
  function automatic logic [31:0] word_of(input int n); return 32'(n * 5 + 7); endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk); s_valid = 1'b1; s_data = w;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    for (int t = 0; t < 3; t++) begin
      for (int b = 0; b < BUFS; b++) mem[tbl_pfn(t) * WPP + b] = 32'(buf_pfn(t, b));
      mem[tbl_pfn(t) * WPP + BUFS] = 32'(tbl_pfn((t + 1) % 3));
    end
    idle(4); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_req == 1'b0, "R1", mem_req, 0);
    chk(s_ready == 1'b0, "R1", s_ready, 0);
    chk(rd_n == 0 && wr_n == 0, "R1", rd_n + wr_n, 0);

    wreg(0, 32'h10); wreg(0, 32'h20); wreg(0, 32'h20);
    wreg(5, 32'd10); wreg(0, 32'h0C000040);
    for (int n = 0; n < 24; n++) send(word_of(n));
    @(negedge clk); s_valid = 1'b1; s_data = word_of(24);
    idle(20);
    begin
      int rq;
      bit seen;
      rq = req_cnt; seen = 1'b0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= s_ready; end
      // R6 zero credit: no request, no accept
      chk(req_cnt == rq, "R6", req_cnt, rq);
      chk(!seen, "R6", seen, 0);
      // R9 non-matching commands add nothing
      wreg(0, 32'h30); wreg(1, 32'h20); wreg(0, 32'h21); wreg(7, 32'h0C000040);
      seen = 1'b0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); seen |= s_ready; end
      chk(!seen && req_cnt == rq, "R9", seen, 0);
    end
    wreg(0, 32'h20);
    for (int n = 24; n < 36; n++) send(word_of(n));
    @(negedge clk); s_valid = 1'b0;
    idle(30);
    wreg(0, 32'h20);
    for (int n = 36; n < 48; n++) send(word_of(n));
    @(negedge clk); s_valid = 1'b0;
    idle(30);

    chk(wr_n == 48, "R3", wr_n, 48);
    for (int n = 0; n < 48 && n < wr_n; n++) begin
      int p, t, b, k;
      logic [31:0] ed;
      p = n / WPP; k = n % WPP; t = (p / BUFS) % 3; b = p % BUFS;
      ed = word_of(n) | ((n == 24 || n == 36) ? 32'h0100_0000 : 32'h0);
      // R3 page/word order, R4 linked table and wrap for n>=24
      chk(wr_addr_log[n] == AW'(buf_pfn(t, b) * WPP + k), (n >= 24) ? "R4" : "R3",
          wr_addr_log[n], buf_pfn(t, b) * WPP + k);
      // R7 overflow marker only after a stall
      chk(wr_data_log[n] == ed, "R7", wr_data_log[n], ed);
    end
    chk(rd_n == 16, "R4", rd_n, 16);
    for (int j = 0; j < 16 && j < rd_n; j++) begin
      int ea;
      ea = tbl_pfn((j / 4) % 3) * WPP + j % 4;
      chk(rd_addr_log[j] == AW'(ea), (j == 0) ? "R2" : "R4", rd_addr_log[j], ea);
    end

    wreg(0, 32'h08080000);
    begin
      int rq;
      bit seen;
      rq = req_cnt; seen = 1'b0;
      @(negedge clk); s_valid = 1'b1; s_data = 32'h55;
      for (int i = 0; i < 20; i++) begin @(negedge clk); seen |= s_ready; end
      s_valid = 1'b0;
      // R8 idle after stop
      chk(req_cnt == rq, "R8", req_cnt, rq);
      chk(!seen, "R8", seen, 0);
    end

    begin
      int rn, wn;
      wreg(0, 32'h10); wreg(5, 32'd20); wreg(0, 32'h0C000040);
      rn = rd_n; wn = wr_n;
      idle(15);
      // R5 cleared credit blocks entry
      chk(rd_n == rn, "R5", rd_n, rn);
      wreg(0, 32'h20);
      idle(15);
      chk(rd_n == rn + 1, "R5", rd_n, rn + 1);
      // R2 start at register 5 table
      chk(rd_addr_log[rn] == AW'(tbl_pfn(1) * WPP), "R2", rd_addr_log[rn], tbl_pfn(1) * WPP);
      for (int n = 0; n < 4; n++) send(word_of(100 + n));
      @(negedge clk); s_valid = 1'b0;
      idle(10);
      chk(wr_n == wn + 4, "R10", wr_n, wn + 4);
      for (int n = 0; n < 4; n++) begin
        logic [31:0] ed;
        ed = word_of(100 + n) | ((n == 0) ? 32'h0100_0000 : 32'h0);
        chk(wr_addr_log[wn + n] == AW'(buf_pfn(1, 0) * WPP + n), "R2",
            wr_addr_log[wn + n], buf_pfn(1, 0) * WPP + n);
        chk(wr_data_log[wn + n] == ed, "R7", wr_data_log[wn + n], ed);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule